// File: doc/BRIEF.md
# Single-Wire Half-Duplex Debug UART

This block carries asynchronous serial characters in both directions over a single open-drain line. It transmits by pulling the line low for zero bits and letting it float high for one bits. It receives on the same line whenever its own transmitter is idle. Each character has one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity.

The bit time is set by a 16-bit baud value. Software can write this value directly. An auto-baud unit can also set it by timing the low stretch of a sync character. The transmitter watches every one bit it releases and reports a collision if another device holds the line low. The receiver reports framing errors, overruns and long breaks. Any of these errors, or a received character that has not been read yet, holds back the next transmission. An enable bit cuts the line off from both engines. A GPIO mode hands the line to software as a plain input or output. An interrupt is raised from a masked set of status sources.

Top module: `sw_dbg_uart`

## Requirements
- R1: A written character is sent as start 0, data LSB first, stop 1, each lasting the baud value in clocks. The block pulls the line low for a 0 and only releases it for a 1. It never drives the line high outside GPIO mode. The receiver is idle while the transmitter is busy.
- R2: Collision check: if the transmitter releases a 1 and the line reads low at mid-bit, the collision flag (status bit 2) is set. The frame is aborted and the line is released.
- R3: A received character is placed in the receive data register (address 3) and sets receive-full (status bit 0). If its stop bit is sampled low, framing error (status bit 3) is also set.
- R4: If a character completes while receive-full is set, overrun (status bit 4) is set and the held character is kept.
- R5: When the line stays low for ten or more bit times, break (status bit 5) is set.
- R6: A written transmit character (address 2) does not start while any of collision, framing, break, overrun or receive-full is set. It starts once they are all cleared.
- R7: When enable (control bit 0) is 0, the block never drives the line and ignores incoming line data. A written transmit character is still consumed, and transmit-empty (status bit 1) is set again.
- R8: The interrupt output is the OR of four sources, each gated by its own mask bit: receive-full/framing/overrun (control bit 8), transmit-empty (bit 9), auto-baud done (bit 10), and break (bit 11).
- R9: In GPIO mode (control bit 1) the line is an input when output-enable (control bit 2) is 0, and its level is reported in status bit 7. When output-enable is 1, the line is driven with the level in control bit 3.
- R10: Writing 1 to control bit 4 arms auto-baud. The low time of the next low stretch, in clocks, divided by 8, is loaded into the baud register (address 4), and auto-baud done (status bit 6) is set.
- R11: Register map: control at address 0, status at address 1. Status bits 2 to 6 stay set until a 1 is written to that bit of the status register. Writing a 0 to a bit leaves it unchanged. Reading the receive data register clears receive-full. After reset, status reads 0x0082.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| line_in | input | 1 | Sensed level of the shared serial line |
| pin_oe | output | 1 | Drive enable for the shared line |
| pin_out | output | 1 | Level driven when pin_oe is high (always 0 outside GPIO mode) |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach from the ports is a collision. Another device has to pull the line low at the exact moment the block releases a one bit, in the middle of the block's own frame. The bench models the shared line as a wired connection between the block's drive and a bench-controlled pull-down. It waits until the block starts driving its start bit, counts one bit time, and then holds the line low across the first data bit of an all-ones character. While that collision flag is still set, the bench writes another character. It checks that this character stays on hold until the flag is cleared, and that it then appears correctly on the line.

// File: rtl/dbgu_pkg.sv
package dbgu_pkg;
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_STAT = 3'd1;
  localparam logic [2:0] ADR_TXD  = 3'd2;
  localparam logic [2:0] ADR_RXD  = 3'd3;
  localparam logic [2:0] ADR_BAUD = 3'd4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/dbgu_bittimer.sv
module dbgu_bittimer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             mid,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= period - 1'b1;
    else if (cnt == '0)   cnt <= period - 1'b1;
    else                  cnt <= cnt - 1'b1;
  end

  assign mid  = run && (cnt == (period >> 1));
  assign done = run && (cnt == '0);
endmodule

// File: rtl/dbgu_tx.sv
module dbgu_tx #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              line,
  input  logic [CNT_W-1:0]  period,
  output logic              busy,
  output logic              level,
  output logic              coll
);
  localparam int FRAME = DATA_W + 2;
  localparam int IDX_W = $clog2(FRAME);

  logic [FRAME-1:0] sh;
  logic [IDX_W-1:0] idx;
  logic             mid, done;

  dbgu_bittimer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .period(period), .mid(mid), .done(done)
  );

  assign level = busy ? sh[0] : 1'b1;
  assign coll  = busy && mid && sh[0] && !line;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sh   <= '1;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sh   <= {1'b1, data, 1'b0};
      idx  <= '0;
    end else if (busy) begin
      if (coll) begin
        busy <= 1'b0;
      end else if (done) begin
        if (idx == IDX_W'(FRAME - 1)) busy <= 1'b0;
        else begin
          sh  <= {1'b1, sh[FRAME-1:1]};
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_TX_ABORT: assert property (@(posedge clk) disable iff (rst) coll |=> !busy); // R2
endmodule

// File: rtl/dbgu_rx.sv
module dbgu_rx
  import dbgu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int BREAK_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              line,
  input  logic [CNT_W-1:0]  period,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ferr,
  output logic              brk
);
  localparam int BW = $clog2(DATA_W);
  localparam int LW = CNT_W + 4;

  rx_state_e        state;
  logic             prev, mid, tend;
  logic [BW-1:0]    nbit;
  logic [DATA_W-1:0] sh;
  logic [LW-1:0]    low_cnt, brk_lim;

  dbgu_bittimer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(state != RX_IDLE), .period(period), .mid(mid), .done(tend)
  );

  assign brk_lim = LW'(period) * LW'(BREAK_BITS);
  assign brk     = (low_cnt == brk_lim);

  always_ff @(posedge clk) begin
    if (rst || hold || line) low_cnt <= '0;
    else if (low_cnt <= brk_lim) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      prev  <= 1'b1;
      nbit  <= '0;
      sh    <= '0;
      done  <= 1'b0;
      data  <= '0;
      ferr  <= 1'b0;
    end else begin
      prev <= line;
      done <= 1'b0;
      if (hold) state <= RX_IDLE;
      else begin
        unique case (state)
          RX_IDLE: if (prev && !line) state <= RX_START;
          RX_START: begin
            if (mid && line) state <= RX_IDLE;
            else if (tend) begin
              state <= RX_DATA;
              nbit  <= '0;
            end
          end
          RX_DATA: begin
            if (mid) sh <= {line, sh[DATA_W-1:1]};
            if (tend) begin
              if (nbit == BW'(DATA_W - 1)) state <= RX_STOP;
              nbit <= nbit + 1'b1;
            end
          end
          RX_STOP: if (mid) begin
            done  <= 1'b1;
            data  <= sh;
            ferr  <= !line;
            state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) hold |=> state == RX_IDLE); // R1
endmodule

// File: rtl/dbgu_autobaud.sv
module dbgu_autobaud #(
  parameter int CNT_W = 16,
  parameter int SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             line,
  output logic             armed,
  output logic             done,
  output logic [CNT_W-1:0] value
);
  localparam int ACC_W = CNT_W + SHIFT;

  logic [ACC_W-1:0] acc;
  logic             meas;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      meas  <= 1'b0;
      acc   <= '0;
      done  <= 1'b0;
      value <= '0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        meas  <= 1'b0;
        acc   <= '0;
      end else if (armed) begin
        if (!line) begin
          meas <= 1'b1;
          if (acc != '1) acc <= acc + 1'b1;
        end else if (meas) begin
          armed <= 1'b0;
          meas  <= 1'b0;
          done  <= 1'b1;
          value <= acc[ACC_W-1:SHIFT];
        end
      end
    end
  end
endmodule

// File: rtl/sw_dbg_uart.sv
module sw_dbg_uart
  import dbgu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BAUD_W     = 16,
  parameter int RST_BAUD   = 16,
  parameter int BREAK_BITS = 10,
  parameter int AB_SHIFT   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        line_in,
  output logic        pin_oe,
  output logic        pin_out,
  output logic        irq
);
  localparam int REG_W = 16;

  logic              en, gpio, goe, glvl;
  logic [3:0]        mask;
  logic              ls1, ls2;
  logic              rx_full, tx_empty, coll_f, frm_f, ovr_f, brk_f, ab_f;
  logic [DATA_W-1:0] tx_hold, rx_data;
  logic [BAUD_W-1:0] baud;

  logic wr_ctrl, wr_stat, wr_txd, wr_baud, rd_rxd;
  logic blocked, tx_start, tx_busy, tx_level, tx_coll;
  logic tx_line, rx_line, rx_hold;
  logic rx_done, rx_ferr, rx_brk;
  logic [DATA_W-1:0] rx_byte;
  logic ab_armed, ab_done;
  logic [BAUD_W-1:0] ab_val;
  logic [REG_W-1:0]  rd_mux;

  assign wr_ctrl = reg_wr && reg_addr == ADR_CTRL;
  assign wr_stat = reg_wr && reg_addr == ADR_STAT;
  assign wr_txd  = reg_wr && reg_addr == ADR_TXD;
  assign wr_baud = reg_wr && reg_addr == ADR_BAUD;
  assign rd_rxd  = reg_rd && reg_addr == ADR_RXD;

  assign blocked  = coll_f || frm_f || ovr_f || brk_f || rx_full;
  assign tx_start = !tx_empty && !tx_busy && !blocked && !gpio && !ab_armed;
  assign tx_line  = (en && !gpio) ? ls2 : tx_level;
  assign rx_line  = (en && !gpio) ? ls2 : 1'b1;
  assign rx_hold  = tx_busy || gpio || ab_armed;

  dbgu_tx #(.DATA_W(DATA_W), .CNT_W(BAUD_W)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .data(tx_hold), .line(tx_line),
    .period(baud), .busy(tx_busy), .level(tx_level), .coll(tx_coll)
  );

  dbgu_rx #(.DATA_W(DATA_W), .CNT_W(BAUD_W), .BREAK_BITS(BREAK_BITS)) u_rx (
    .clk(clk), .rst(rst), .hold(rx_hold), .line(rx_line), .period(baud),
    .done(rx_done), .data(rx_byte), .ferr(rx_ferr), .brk(rx_brk)
  );

  dbgu_autobaud #(.CNT_W(BAUD_W), .SHIFT(AB_SHIFT)) u_ab (
    .clk(clk), .rst(rst), .arm(wr_ctrl && reg_wdata[4]), .line(rx_line),
    .armed(ab_armed), .done(ab_done), .value(ab_val)
  );

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      ADR_CTRL: rd_mux = {4'b0, mask, 3'b0, ab_armed, glvl, goe, gpio, en};
      ADR_STAT: rd_mux = {7'b0, tx_busy, ls2, ab_f, brk_f, ovr_f, frm_f, coll_f, tx_empty, rx_full};
      ADR_RXD:  rd_mux = REG_W'(rx_data);
      ADR_BAUD: rd_mux = REG_W'(baud);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {en, gpio, goe, glvl} <= '0;
      mask      <= '0;
      ls1       <= 1'b1;
      ls2       <= 1'b1;
      rx_full   <= 1'b0;
      tx_empty  <= 1'b1;
      {coll_f, frm_f, ovr_f, brk_f, ab_f} <= '0;
      tx_hold   <= '0;
      rx_data   <= '0;
      baud      <= BAUD_W'(RST_BAUD);
      irq       <= 1'b0;
      pin_oe    <= 1'b0;
      pin_out   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ls1 <= line_in;
      ls2 <= ls1;
      if (wr_ctrl) begin
        {glvl, goe, gpio, en} <= reg_wdata[3:0];
        mask <= reg_wdata[11:8];
      end
      if (wr_txd) begin
        tx_hold  <= reg_wdata[DATA_W-1:0];
        tx_empty <= 1'b0;
      end else if (tx_start) tx_empty <= 1'b1;
      if (rx_done && !rx_full) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
      end else if (rd_rxd) rx_full <= 1'b0;
      coll_f <= (coll_f && !(wr_stat && reg_wdata[2])) || tx_coll;
      frm_f  <= (frm_f  && !(wr_stat && reg_wdata[3])) || (rx_done && !rx_full && rx_ferr);
      ovr_f  <= (ovr_f  && !(wr_stat && reg_wdata[4])) || (rx_done && rx_full);
      brk_f  <= (brk_f  && !(wr_stat && reg_wdata[5])) || rx_brk;
      ab_f   <= (ab_f   && !(wr_stat && reg_wdata[6])) || ab_done;
      if (ab_done) baud <= ab_val;
      else if (wr_baud) baud <= reg_wdata[BAUD_W-1:0];
      irq     <= |(mask & {brk_f, ab_f, tx_empty, rx_full || frm_f || ovr_f});
      pin_oe  <= gpio ? goe : (en && tx_busy && !tx_level);
      pin_out <= gpio && glvl;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst) !gpio |=> !(pin_oe && pin_out)); // R1
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst) (!en && !gpio) |=> !pin_oe); // R7
  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (rst) (blocked && !tx_busy) |=> !tx_busy); // R6
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (rst) (rx_done && rx_full) |=> $stable(rx_data)); // R4
  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (rst) (frm_f && !(wr_stat && reg_wdata[3])) |=> frm_f); // R11
endmodule

// File: tb/test_sw_dbg_uart.sv
module test_sw_dbg_uart;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_oe, pin_out, irq;
  logic        ext_lo = 1'b0;
  logic        line;

  int checks = 0, fails = 0, drv_cnt = 0, bitp = 16;
  bit mon_en = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;
  assign line = pin_oe ? pin_out : !ext_lo;

  sw_dbg_uart i_sw_dbg_uart (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line),
    .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queue the expected line character, then hand it to the block
  task automatic send_dut(input logic [7:0] b);
    exp_q.push_back(b);
    wr(3'd2, {8'h00, b});
  endtask

  task automatic ext_send(input logic [7:0] b, input logic stop_hi);
    @(negedge clk);
    ext_lo = 1'b1; idle(bitp);
    for (int i = 0; i < 8; i++) begin ext_lo = !b[i]; idle(bitp); end
    ext_lo = !stop_hi; idle(bitp);
    ext_lo = 1'b0; idle(2 * bitp);
  endtask

  // monitor: decode frames the block starts and compare with the queue
  initial begin
    logic lp = 1'b1;
    forever begin
      @(negedge clk);
      if (pin_oe && !pin_out) drv_cnt++;
      if (mon_en && lp && !line && pin_oe) begin
        logic [7:0] got;
        logic st, sp;
        idle(bitp / 2); st = line;
        for (int i = 0; i < 8; i++) begin idle(bitp); got[i] = line; end
        idle(bitp); sp = line;
        if (exp_q.size() == 0) chk("R1 unexpected frame", got, -1);
        else chk("R1 frame byte", got, exp_q.pop_front());
        chk("R1 start/stop levels", {st, sp}, 2'b01);
      end
      lp = line;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    idle(4); rst = 1'b0; idle(4);
    rd(3'd1, d); chk("R11 reset status", d, 16'h0082);
    chk("R1 reset no drive", pin_oe, 0);
    chk("R8 reset irq", irq, 0);

    // R1 transmit
    wr(3'd0, 16'h0001); mon_en = 1'b1;
    send_dut(8'hA5); idle(12 * bitp);
    send_dut(8'h3C); idle(12 * bitp);

    // R3 receive, clean then framing error; R11 write-one-to-clear
    ext_send(8'h5A, 1'b1);
    rd(3'd1, d); chk("R3 rx full", d[3:0], 4'h3);
    rd(3'd3, d); chk("R3 rx data", d, 16'h005A);
    rd(3'd1, d); chk("R11 read clears rx full", d[0], 0);
    ext_send(8'h33, 1'b0);
    rd(3'd1, d); chk("R3 framing flag", d[3], 1);
    rd(3'd3, d); chk("R3 data with framing", d, 16'h0033);
    wr(3'd1, 16'h0014);
    rd(3'd1, d); chk("R11 w0 keeps framing", d[3], 1);
    wr(3'd1, 16'h0008);
    rd(3'd1, d); chk("R11 w1c framing", d[3], 0);

    // R4 overrun
    ext_send(8'h11, 1'b1);
    ext_send(8'h22, 1'b1);
    rd(3'd1, d); chk("R4 overrun flag", d[4], 1);
    rd(3'd3, d); chk("R4 held data", d, 16'h0011);
    wr(3'd1, 16'h0010);

    // R6 blocked by unread receive data
    ext_send(8'h44, 1'b1);
    drv_cnt = 0;
    send_dut(8'h77); idle(12 * bitp);
    chk("R6 no start while rx full", drv_cnt, 0);
    rd(3'd3, d); idle(12 * bitp);

    // R2 collision
    mon_en = 1'b0;
    wr(3'd2, 16'h00FF);
    while (!pin_oe) @(negedge clk);
    idle(bitp); ext_lo = 1'b1; idle(bitp);
    chk("R2 line released after collision", pin_oe, 0);
    ext_lo = 1'b0; idle(2);
    rd(3'd1, d); chk("R2 collision flag", d[2], 1);
    chk("R2 frame aborted", d[8], 0);
    mon_en = 1'b1; drv_cnt = 0;
    send_dut(8'h12); idle(12 * bitp);
    chk("R6 no start while collision", drv_cnt, 0);
    wr(3'd1, 16'h0004); idle(12 * bitp);

    // R5 break
    @(negedge clk); ext_lo = 1'b1; idle(11 * bitp); ext_lo = 1'b0; idle(2 * bitp);
    rd(3'd1, d); chk("R5 break flag", d[5], 1);
    rd(3'd3, d); chk("R5 break char", d, 16'h0000);
    wr(3'd1, 16'h007C);
    rd(3'd1, d); chk("R11 all cleared", d[6:2], 5'h00);

    // R8 interrupt masking
    wr(3'd0, 16'h0101); idle(3);
    chk("R8 irq idle masked", irq, 0);
    ext_send(8'h66, 1'b1);
    chk("R8 irq on rx full", irq, 1);
    rd(3'd3, d); idle(3);
    chk("R8 irq drops after read", irq, 0);
    wr(3'd0, 16'h0201); idle(3);
    chk("R8 irq on tx empty", irq, 1);

    // R7 disabled
    wr(3'd0, 16'h0000); mon_en = 1'b0; drv_cnt = 0;
    wr(3'd2, 16'h0055); idle(12 * bitp);
    chk("R7 no drive when off", drv_cnt, 0);
    rd(3'd1, d); chk("R7 tx drained", {d[8], d[1]}, 2'b01);
    ext_send(8'h99, 1'b1);
    rd(3'd1, d); chk("R7 rx ignored", d[0], 0);

    // R9 GPIO
    wr(3'd0, 16'h0002);
    @(negedge clk); ext_lo = 1'b1; idle(4);
    rd(3'd1, d); chk("R9 input low", d[7], 0);
    ext_lo = 1'b0; idle(4);
    rd(3'd1, d); chk("R9 input high", d[7], 1);
    wr(3'd0, 16'h0006); idle(2);
    chk("R9 drive low", {pin_oe, pin_out}, 2'b10);
    wr(3'd0, 16'h000E); idle(2);
    chk("R9 drive high", {pin_oe, pin_out}, 2'b11);

    // R10 auto-baud
    wr(3'd0, 16'h0011);
    @(negedge clk); ext_lo = 1'b1; idle(96); ext_lo = 1'b0; idle(4);
    rd(3'd1, d); chk("R10 done flag", d[6], 1);
    rd(3'd4, d); chk("R10 baud loaded", d, 12);
    wr(3'd1, 16'h0040);
    bitp = 12; mon_en = 1'b1;
    send_dut(8'hC3); idle(12 * bitp);
    wr(3'd4, 16'd20); bitp = 20;
    send_dut(8'h81); idle(12 * bitp);
    chk("R1 all frames seen", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule